// File: doc/BRIEF.md
# Completion Request Tracking Status Unit

This unit sits beside the request issue logic of a DMA channel controller. It keeps a count of the transfer requests that were sent to the transfer engines with a request for a completion report, and that have not yet been answered. A request counts if it asks for a completion interrupt or for completion chaining, or for both. Each valid completion code that a transfer engine returns lowers the count by one. The count is 6 bits wide. When it reaches its ceiling of 63, the unit holds off further issue through a stall output. Issue resumes as soon as a return brings the count below the ceiling.

The unit also builds a read-only 32-bit status word. The word holds the outstanding count, one activity flag for each of the four request queues, and four controller activity flags. The word is registered on every clock edge. It is read through a read-enable and read-data pair, and reading has no side effects. A return that arrives while nothing is outstanding is dropped, and the unit signals it with a one-cycle error pulse.

Top module: `cmpl_track_status`

## Requirements
- R1: In reset (`rst_n` low at a clock edge), the outstanding count goes to 0, and the status word, `stall` and `ret_err` go to 0.
- R2: A submit (`sub_vld`=1) with `sub_irq_en` or `sub_chain_en` set, accepted while `stall` is low and with no effective return in the same cycle, raises the count by one at that clock edge.
- R3: A submit with both flags clear leaves the count unchanged. So do flags presented without `sub_vld`.
- R4: A return (`ret_vld`=1) while the count is nonzero lowers the count by one, if no counted submit is accepted in the same cycle.
- R5: A counted submit that is accepted in the same cycle as a return, with the count nonzero, leaves the count unchanged.
- R6: A return while the count is 0 is ignored, so the count never goes below 0. `ret_err` is high for exactly the one cycle after that edge. If a counted submit comes in the same cycle, the count becomes 1.
- R7: `stall` is high exactly while the count equals 63. A counted submit while `stall` is high is dropped. A return at 63 brings the count to 62 and clears `stall` in the same edge.
- R8: Status bits 19:16 hold the occupancy of queues 3..0 (bit 16 = queue 0). Bits 13:8 hold the outstanding count. The status register loads these at every clock edge, so the word reflects the values present one edge earlier.
- R9: Status bit 0 holds event activity, bit 1 queue-event activity, bit 2 transfer-request activity and bit 4 overall controller activity. Bits 31:20, 15:14, 7:5 and 3 always read 0.
- R10: `rd_data` equals the status word while `rd_en` is high and reads 0 while it is low. A read changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sub_vld | input | 1 | Request submitted this cycle |
| sub_irq_en | input | 1 | Submitted request wants a completion interrupt |
| sub_chain_en | input | 1 | Submitted request wants completion chaining |
| ret_vld | input | 1 | Valid completion code returned by a transfer engine |
| q_busy | input | 4 | Queue n holds at least one request |
| evt_busy | input | 1 | Event logic active |
| qevt_busy | input | 1 | Queue-event logic active |
| tr_busy | input | 1 | Transfer-request logic active |
| ctl_busy | input | 1 | Controller active overall |
| rd_en | input | 1 | Status read enable |
| rd_data | output | 32 | Status word while reading, else 0 |
| stall | output | 1 | Hold off new request issue (count full) |
| ret_err | output | 1 | One-cycle pulse after a return at count 0 |

## Verification
The hardest state to reach is the full count. It takes 63 accepted counted submits with no returns between them, and the cases at the ceiling all depend on it: a submit dropped while stalled, a return that frees the stall, and a submit paired with a return at 62. After a vector table has mixed the flags, the bench fills the counter with a directed loop, using a running model of the count. It then applies these cases at the ceiling. Later it drains the counter to zero to check returns that arrive with nothing outstanding.

// File: rtl/cts_pkg.sv
// Package: shared constants and types for the completion tracking unit.
// Assumes a 32-bit status word whose field positions are fixed by the
// software-visible layout; only the widths are tunable.
package cts_pkg;
    localparam int STAT_W   = 32;
    localparam int CNT_W    = 6;
    localparam int NUM_Q    = 4;
    localparam int CNT_LSB  = 8;
    localparam int QACT_LSB = 16;
    localparam int EVT_BIT  = 0;
    localparam int QEVT_BIT = 1;
    localparam int TR_BIT   = 2;
    localparam int CTL_BIT  = 4;

    // Activity indications gathered from the rest of the controller.
    typedef struct packed {
        logic ctl;
        logic tr;
        logic qevt;
        logic evt;
    } act_t;
endpackage

// File: rtl/cts_cmpl_counter.sv
// Module: saturating counter of the completion requests that are still
// outstanding. Counted submits are accepted only while not stalled, so
// the count cannot pass its ceiling. Returns at zero are dropped and
// flagged. Assumes a single submit and a single return at most per cycle.
module cts_cmpl_counter #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sub_vld,
    input  logic             sub_irq_en,
    input  logic             sub_chain_en,
    input  logic             ret_vld,
    output logic [CNT_W-1:0] cnt,
    output logic             stall,
    output logic             ret_err
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic             wants_rpt;
    logic             take;
    logic             is_zero;
    logic             give;
    logic             drop_ret;
    logic [CNT_W-1:0] cnt_nxt;

    // Decode which events actually move the counter this cycle.
    always_comb begin
        wants_rpt = sub_vld & (sub_irq_en | sub_chain_en);
        take      = wants_rpt & ~stall;
        is_zero   = (cnt == CNT_ZERO);
        give      = ret_vld & ~is_zero;
        drop_ret  = ret_vld & is_zero;
    end

    // Next count: a simultaneous take and give cancel out.
    always_comb begin
        case ({take, give})
            2'b10:   cnt_nxt = cnt + CNT_ONE;
            2'b01:   cnt_nxt = cnt - CNT_ONE;
            default: cnt_nxt = cnt;
        endcase
    end

    // Count register and the registered error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= CNT_ZERO;
            ret_err <= 1'b0;
        end else begin
            cnt     <= cnt_nxt;
            ret_err <= drop_ret;
        end
    end

    // Throttle issue while the count sits at its ceiling.
    always_comb stall = (cnt == CNT_MAX);

    a_r2_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_vld && (sub_irq_en || sub_chain_en) && !stall && !ret_vld)
        |=> (cnt == $past(cnt) + CNT_ONE));
    a_r3_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (!(sub_irq_en || sub_chain_en) && !ret_vld) |=> $stable(cnt));
    a_r4_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_vld && cnt != CNT_ZERO && !(sub_vld && (sub_irq_en || sub_chain_en)))
        |=> (cnt == $past(cnt) - CNT_ONE));
    a_r5_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_vld && cnt != CNT_ZERO && cnt != CNT_MAX && sub_vld && sub_irq_en)
        |=> $stable(cnt));
    a_r6_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_vld && cnt == CNT_ZERO) |=> ret_err);
    a_r7_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && !ret_vld) |=> (cnt == CNT_MAX));
endmodule

// File: rtl/cts_status_pack.sv
// Module: places the count, the queue flags and the activity flags into
// the 32-bit status word and registers it every clock. Reserved bits are
// tied to zero. Assumes NUM_Q queue flags fit below bit 20.
module cts_status_pack
    import cts_pkg::*;
#(
    parameter int CNT_W = cts_pkg::CNT_W,
    parameter int NUM_Q = cts_pkg::NUM_Q
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [NUM_Q-1:0]  q_busy,
    input  act_t              act,
    output logic [STAT_W-1:0] status
);
    logic [STAT_W-1:0] word;
    logic [NUM_Q-1:0]  q_flag;

    // One flag per queue, kept in a separate vector before packing.
    for (genvar q = 0; q < NUM_Q; q++) begin : g_qflag
        assign q_flag[q] = q_busy[q];
    end

    // Assemble the word; everything not written stays zero.
    always_comb begin
        word                     = '0;
        word[CNT_LSB +: CNT_W]   = cnt;
        word[QACT_LSB +: NUM_Q]  = q_flag;
        word[EVT_BIT]            = act.evt;
        word[QEVT_BIT]           = act.qevt;
        word[TR_BIT]             = act.tr;
        word[CTL_BIT]            = act.ctl;
    end

    // Status register, reloaded every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= word;
    end

    a_r8_queue_flags: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (status[QACT_LSB +: NUM_Q] == $past(q_busy)));
    a_r9_ctl_flag: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (status[CTL_BIT] == $past(act.ctl)));
endmodule

// File: rtl/cts_status_read.sv
// Module: side-effect-free read port that gates the status word onto the
// read data bus. Assumes the reader samples in the same cycle.
module cts_status_read
    import cts_pkg::*;
(
    input  logic              rd_en,
    input  logic [STAT_W-1:0] status,
    output logic [STAT_W-1:0] rd_data
);
    // Drive the word only while a read is enabled.
    always_comb rd_data = rd_en ? status : '0;
endmodule

// File: rtl/cmpl_track_status.sv
// Module: top of the completion tracking status unit. Connects the
// counter, the status packer and the read port. Assumes all inputs are
// synchronous to clk.
module cmpl_track_status
    import cts_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sub_vld,
    input  logic        sub_irq_en,
    input  logic        sub_chain_en,
    input  logic        ret_vld,
    input  logic [3:0]  q_busy,
    input  logic        evt_busy,
    input  logic        qevt_busy,
    input  logic        tr_busy,
    input  logic        ctl_busy,
    input  logic        rd_en,
    output logic [31:0] rd_data,
    output logic        stall,
    output logic        ret_err
);
    logic [CNT_W-1:0]  cnt;
    logic [STAT_W-1:0] status;
    act_t              act;

    // Group the activity indications.
    always_comb begin
        act.evt  = evt_busy;
        act.qevt = qevt_busy;
        act.tr   = tr_busy;
        act.ctl  = ctl_busy;
    end

    cts_cmpl_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .sub_vld(sub_vld), .sub_irq_en(sub_irq_en),
        .sub_chain_en(sub_chain_en), .ret_vld(ret_vld), .cnt(cnt),
        .stall(stall), .ret_err(ret_err)
    );

    cts_status_pack #(.CNT_W(CNT_W), .NUM_Q(NUM_Q)) u_pack (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .q_busy(q_busy), .act(act),
        .status(status)
    );

    cts_status_read u_rd (
        .rd_en(rd_en), .status(status), .rd_data(rd_data)
    );

    a_r7_stall_full: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && sub_vld && sub_irq_en && !ret_vld) |=> stall);
endmodule

// File: tb/cmpl_track_status_tb.sv
module cmpl_track_status_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        sub_vld, sub_irq_en, sub_chain_en, ret_vld;
    logic [3:0]  q_busy;
    logic        evt_busy, qevt_busy, tr_busy, ctl_busy;
    logic        rd_en;
    logic [31:0] rd_data;
    logic        stall, ret_err;

    int n_chk  = 0;
    int n_fail = 0;
    int model  = 0;

    always #5ns clk = ~clk;

    cmpl_track_status u_dut (
        .clk(clk), .rst_n(rst_n), .sub_vld(sub_vld), .sub_irq_en(sub_irq_en),
        .sub_chain_en(sub_chain_en), .ret_vld(ret_vld), .q_busy(q_busy),
        .evt_busy(evt_busy), .qevt_busy(qevt_busy), .tr_busy(tr_busy),
        .ctl_busy(ctl_busy), .rd_en(rd_en), .rd_data(rd_data),
        .stall(stall), .ret_err(ret_err)
    );

    // Vector: {sub, irq, chain, ret, q[3:0], act{ctl,tr,qevt,evt}}
    localparam logic [11:0] VEC [12] = '{
        12'b1100_0001_0001,  // R2 irq flag
        12'b1010_0010_0010,  // R2 chain flag
        12'b1110_0100_0100,  // R2 both flags
        12'b1000_1000_1000,  // R3 no flags
        12'b0001_1111_1111,  // R4 return
        12'b1101_0000_0000,  // R5 submit + return
        12'b0110_1010_0101,  // R3 flags without submit
        12'b0001_0101_1010,  // R4
        12'b0001_0011_1100,  // R4 to zero
        12'b0001_0000_0000,  // R6 return at zero
        12'b1011_1100_0011,  // R6 submit + return at zero -> 1
        12'b0000_0101_1010   // R8/R9 flags only
    };

    function automatic logic [31:0] exp_word(int c, logic [3:0] q, logic [3:0] a);
        logic [31:0] w = '0;
        w[13:8]  = 6'(c);
        w[19:16] = q;
        w[4]     = a[3];
        w[2]     = a[2];
        w[1]     = a[1];
        w[0]     = a[0];
        return w;
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Advance the bench model the same way the requirements describe.
    task automatic model_step(logic s, logic i, logic c, logic r);
        logic tk = s && (i || c) && (model != 63);
        logic gv = r && (model != 0);
        if (tk && !gv) model++;
        else if (gv && !tk) model--;
    endtask

    // One-cycle strobe; outputs of the counter are valid at the next negedge.
    task automatic pulse(logic s, logic i, logic c, logic r);
        sub_vld = s; sub_irq_en = i; sub_chain_en = c; ret_vld = r;
        model_step(s, i, c, r);
        @(negedge clk);
        sub_vld = 0; sub_irq_en = 0; sub_chain_en = 0; ret_vld = 0;
    endtask

    initial begin
        #2ms;
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 0; sub_vld = 0; sub_irq_en = 0; sub_chain_en = 0; ret_vld = 0;
        q_busy = 4'hF; evt_busy = 1; qevt_busy = 1; tr_busy = 1; ctl_busy = 1;
        rd_en = 1;
        repeat (3) @(negedge clk);
        // R1 reset state (inputs busy, word must still be 0)
        check("R1 status", rd_data, 32'h0);
        check("R1 stall/err", {30'd0, stall, ret_err}, 32'h0);
        rst_n = 1;
        q_busy = 0; evt_busy = 0; qevt_busy = 0; tr_busy = 0; ctl_busy = 0;

        // Table walk: strobe one cycle, hold flags, read one edge later.
        for (int k = 0; k < 12; k++) begin
            q_busy = VEC[k][7:4];
            {ctl_busy, tr_busy, qevt_busy, evt_busy} = VEC[k][3:0];
            pulse(VEC[k][11], VEC[k][10], VEC[k][9], VEC[k][8]);
            @(negedge clk);
            check($sformatf("R2-R9 vec%0d word", k), rd_data,
                  exp_word(model, VEC[k][7:4], VEC[k][3:0]));
            check($sformatf("R7 vec%0d stall", k), {31'd0, stall}, 32'd0);
        end

        // R10 read gating and no side effect
        rd_en = 0; @(negedge clk);
        check("R10 rd_en low", rd_data, 32'h0);
        rd_en = 1; @(negedge clk);
        check("R10 no side effect", rd_data, exp_word(model, 4'b0101, 4'b1010));
        q_busy = 0; {ctl_busy, tr_busy, qevt_busy, evt_busy} = 4'h0;

        // R7 fill to the ceiling
        while (model < 63) pulse(1, 1, 0, 0);
        check("R7 stall at 63", {31'd0, stall}, 32'd1);
        @(negedge clk);
        check("R7 count 63", {26'd0, rd_data[13:8]}, 32'd63);
        pulse(1, 0, 1, 0);
        @(negedge clk);
        check("R7 submit dropped", {26'd0, rd_data[13:8]}, 32'd63);
        pulse(0, 0, 0, 1);
        check("R7 stall released", {31'd0, stall}, 32'd0);
        @(negedge clk);
        check("R7 count 62", {26'd0, rd_data[13:8]}, 32'd62);
        pulse(1, 1, 1, 1);
        @(negedge clk);
        check("R5 cancel at 62", {26'd0, rd_data[13:8]}, 32'd62);

        // R6 drain then return at zero
        while (model > 0) pulse(0, 0, 0, 1);
        check("R6 no err while draining", {31'd0, ret_err}, 32'd0);
        pulse(0, 0, 0, 1);
        check("R6 err pulse", {31'd0, ret_err}, 32'd1);
        @(negedge clk);
        check("R6 err one cycle", {31'd0, ret_err}, 32'd0);
        check("R6 no underflow", {26'd0, rd_data[13:8]}, 32'd0);

        // R1 reset in the middle of activity
        pulse(1, 1, 0, 0); pulse(1, 1, 0, 0);
        rst_n = 0; @(negedge clk); rst_n = 1; model = 0;
        check("R1 mid-run word", rd_data, 32'h0);
        @(negedge clk);
        check("R1 mid-run count", {26'd0, rd_data[13:8]}, 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule